// File: doc/BRIEF.md
# Ping-pong receive buffer controller

This block is the receive side of a small Ethernet MAC. Frames arrive as a byte stream with start and end markers. Each frame is stored in one of two frame buffers, and the host reads those buffers as 32-bit words over a simple register bus. The block has no address filtering, FCS check or PHY logic. The byte stream stands in for all of that.

Each buffer has a status register with two bits: a done flag, which the hardware sets when a frame has been stored, and an interrupt enable. The host empties a buffer and then writes its done bit to zero, which hands the buffer back.

Storage alternates between the two buffers. When the buffer that is due is still held by the host, the frame goes into the other one. When both are held, the frame is discarded and a drop counter counts it. An interrupt pulse tells the host that a frame has landed. The host reads the type/length field from bytes 12 and 13 of the frame, which is word 3, lanes 0 and 1.

Top module: `pingpong_rx`

## Requirements
- R1: After reset, both done bits, both interrupt enables, the global enable, `irq` and `drop_count` are zero. The first frame goes to buffer 0.
- R2: Byte n of a stored frame sits at byte offset n from its buffer base. Buffer 0 starts at 0x1000 and buffer 1 at 0x1800. Word n/4 holds byte n in bits [8*(n%4)+7 : 8*(n%4)], so the first byte is in the lowest lane.
- R3: When the end-of-frame byte of a stored frame is taken, the done bit of that buffer is set. The done bit is bit 0 of the status word. Buffer 0's status word is at 0x17FC and buffer 1's is at 0x1FFC.
- R4: After a frame is stored in one buffer, the next frame is aimed at the other buffer.
- R5: If the buffer that is due has its done bit set and the other buffer's done bit is clear, the frame goes to the other buffer.
- R6: If both done bits are set when a frame starts, the frame is discarded. `drop_count` increases by one, and no buffer content or status changes.
- R7: A host write to a status word with bit 0 equal to 0 clears that done bit. Writing bit 0 as 1 never sets it. Bit 3 is the buffer's interrupt enable, which can be read and written.
- R8: The global interrupt enable is bit 31 of the word at 0x07F8, which can be read and written.
- R9: `irq` is high for exactly one cycle, the cycle after a done bit goes from 0 to 1, provided that buffer's enable and the global enable are both set. Otherwise `irq` stays low.
- R10: Bytes at index 1518 and above are not stored, and they do not spill into the other buffer. The done bit is still set at the end of the frame.
- R11: `bus_rdata` shows the word at the address presented one cycle earlier. Addresses that map to no register, and buffer words beyond the capacity, read as zero.
- R12: The choice of buffer for a frame is made from the done bits as they stand before any host write in the same cycle as the start of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A receive byte is present |
| rx_sof | input | 1 | The current byte is the first of a frame |
| rx_eof | input | 1 | The current byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| bus_addr | input | 13 | Host byte address |
| bus_we | input | 1 | Host write strobe |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, one cycle after the address |
| irq | output | 1 | Frame-received interrupt pulse |
| drop_count | output | DROP_W | Number of frames discarded because both buffers were full |

## Verification
The host's release of a buffer can fall in the same cycle as the receive side's use of the status bits, and there are two such cases.

- **Start of frame meets release.** The bench fills both buffers, then drives the start of a frame in the same cycle as a host write that releases buffer 1. The frame must be dropped, because the decision uses the done bits from before the write. The release must still take effect.
- **End of frame meets release.** A frame's last byte is given in the same cycle as the host releases the other buffer. Afterwards the bench reads both status words and expects both changes: the new done bit set and the released one clear.

// File: rtl/pprx_pkg.sv
package pprx_pkg;

  localparam logic [12:0] GIE_ADDR   = 13'h07F8;
  localparam logic [12:0] STAT0_ADDR = 13'h17FC;
  localparam logic [12:0] STAT1_ADDR = 13'h1FFC;

  typedef struct packed {
    logic ok;
    logic sel;
  } pick_t;

  // Choose a buffer: the one due, else the other, else none
  function automatic pick_t pick_buffer(logic nxt, logic [1:0] done);
    pick_t p;
    p.ok  = 1'b1;
    p.sel = nxt;
    if (done[nxt]) begin
      if (!done[~nxt]) p.sel = ~nxt;
      else             p.ok  = 1'b0;
    end
    return p;
  endfunction

  function automatic int words_for(int bytes);
    return (bytes + 3) / 4;
  endfunction

  function automatic logic [31:0] status_word(logic done, logic ie);
    return {28'd0, ie, 2'b00, done};
  endfunction

endpackage

// File: rtl/pprx_fill.sv
module pprx_fill
  import pprx_pkg::*;
#(
  parameter int MAX_BYTES = 1518,
  parameter int IDX_W     = 9,
  parameter int DROP_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic [1:0]        done,
  output logic              wr_en,
  output logic              wr_sel,
  output logic [IDX_W-1:0]  wr_word,
  output logic [1:0]        wr_lane,
  output logic [7:0]        wr_data,
  output logic              frame_done,
  output logic [1:0]        set_done,
  output logic              drop_evt,
  output logic [DROP_W-1:0] drop_count
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);

  logic             active, sel, nxt, byte_ok, start;
  logic [CNT_W-1:0] cnt, byte_idx;
  pick_t            pick;

  always_comb begin
    pick  = pick_buffer(nxt, done);
    start = rx_valid && rx_sof;
    if (start) begin
      wr_sel   = pick.sel;
      byte_ok  = pick.ok;
      byte_idx = '0;
    end else begin
      wr_sel   = sel;
      byte_ok  = active;
      byte_idx = cnt;
    end
    wr_en      = rx_valid && byte_ok && (byte_idx < CNT_W'(MAX_BYTES));
    wr_word    = IDX_W'(byte_idx >> 2);
    wr_lane    = byte_idx[1:0];
    wr_data    = rx_data;
    frame_done = rx_valid && rx_eof && byte_ok;
    set_done   = frame_done ? (wr_sel ? 2'b10 : 2'b01) : 2'b00;
    drop_evt   = start && !pick.ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      sel        <= 1'b0;
      nxt        <= 1'b0;
      cnt        <= '0;
      drop_count <= '0;
    end else begin
      if (start) begin
        active <= pick.ok && !rx_eof;
        sel    <= pick.sel;
        cnt    <= CNT_W'(1);
      end else if (rx_valid && active) begin
        if (cnt < CNT_W'(MAX_BYTES)) cnt <= cnt + CNT_W'(1);
        if (rx_eof) active <= 1'b0;
      end
      if (frame_done) nxt <= ~wr_sel;
      if (drop_evt) drop_count <= drop_count + DROP_W'(1);
    end
  end

endmodule

// File: rtl/pprx_store.sv
module pprx_store #(
  parameter int WORDS = 380,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [IDX_W-1:0] wr_word,
  input  logic [1:0]       wr_lane,
  input  logic [7:0]       wr_data,
  input  logic             rd_sel,
  input  logic [IDX_W-1:0] rd_word,
  output logic [31:0]      rd_data
);
  localparam int DEPTH = 2 * WORDS;
  localparam int AW    = $clog2(DEPTH);

  logic [3:0][7:0] mem [DEPTH];
  logic [AW-1:0]   wa, ra;

  assign wa = wr_sel ? AW'(WORDS) + AW'(wr_word) : AW'(wr_word);
  assign ra = rd_sel ? AW'(WORDS) + AW'(rd_word) : AW'(rd_word);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wa][wr_lane] <= wr_data;
    rd_data <= mem[ra];
  end

endmodule

// File: rtl/pprx_regs.sv
module pprx_regs
  import pprx_pkg::*;
#(
  parameter int WORDS = 380,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [12:0]      bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  input  logic [1:0]       set_done,
  input  logic [31:0]      mem_q,
  output logic [1:0]       done,
  output logic [1:0]       ie,
  output logic             gie,
  output logic [1:0]       rise,
  output logic             rd_sel,
  output logic [IDX_W-1:0] rd_word,
  output logic [31:0]      bus_rdata,
  output logic             irq
);
  logic [1:0]  hit_stat;
  logic        hit_gie, in_data, q_mem, wdata_unused;
  logic [8:0]  offs;
  logic [31:0] reg_val, q_reg;

  for (genvar g = 0; g < 2; g++) begin : g_buf
    logic [12:0] my_addr;
    logic        d_q, e_q;
    assign my_addr     = (g == 0) ? STAT0_ADDR : STAT1_ADDR;
    assign hit_stat[g] = (bus_addr == my_addr);
    assign done[g]     = d_q;
    assign ie[g]       = e_q;
    assign rise[g]     = set_done[g] & ~d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= 1'b0;
        e_q <= 1'b0;
      end else begin
        if (set_done[g])                                d_q <= 1'b1;
        else if (bus_we && hit_stat[g] && !bus_wdata[0]) d_q <= 1'b0;
        if (bus_we && hit_stat[g]) e_q <= bus_wdata[3];
      end
    end
  end

  assign wdata_unused = ^{bus_wdata[30:4], bus_wdata[2:1]};

  always_comb begin
    hit_gie = (bus_addr == GIE_ADDR);
    offs    = bus_addr[10:2];
    in_data = bus_addr[12] && (offs < 9'(WORDS));
    rd_sel  = bus_addr[11];
    rd_word = IDX_W'(offs);
    if (hit_stat[0])      reg_val = status_word(done[0], ie[0]);
    else if (hit_stat[1]) reg_val = status_word(done[1], ie[1]);
    else if (hit_gie)     reg_val = {gie, 31'd0};
    else                  reg_val = 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie   <= 1'b0;
      irq   <= 1'b0;
      q_mem <= 1'b0;
      q_reg <= 32'd0;
    end else begin
      if (bus_we && hit_gie) gie <= bus_wdata[31];
      irq   <= gie && |(rise & ie);
      q_mem <= in_data;
      q_reg <= reg_val;
    end
  end

  assign bus_rdata = q_mem ? mem_q : q_reg;

endmodule

// File: rtl/pingpong_rx.sv
module pingpong_rx #(
  parameter int MAX_BYTES = 1518,
  parameter int DROP_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic [12:0]       bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [DROP_W-1:0] drop_count
);
  import pprx_pkg::*;

  localparam int WORDS = words_for(MAX_BYTES);
  localparam int IDX_W = $clog2(WORDS);

  logic             wr_en, wr_sel, frame_done, drop_evt, gie_q, rd_sel;
  logic [IDX_W-1:0] wr_word, rd_word;
  logic [1:0]       wr_lane, set_done, done_q, ie_q, rise;
  logic [7:0]       wr_data;
  logic [31:0]      mem_q;

  pprx_fill #(.MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W), .DROP_W(DROP_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .done(done_q),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_word(wr_word), .wr_lane(wr_lane),
    .wr_data(wr_data), .frame_done(frame_done), .set_done(set_done),
    .drop_evt(drop_evt), .drop_count(drop_count)
  );

  pprx_store #(.WORDS(WORDS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_sel(wr_sel), .wr_word(wr_word),
    .wr_lane(wr_lane), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_word(rd_word), .rd_data(mem_q)
  );

  pprx_regs #(.WORDS(WORDS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .set_done(set_done), .mem_q(mem_q),
    .done(done_q), .ie(ie_q), .gie(gie_q), .rise(rise), .rd_sel(rd_sel),
    .rd_word(rd_word), .bus_rdata(bus_rdata), .irq(irq)
  );

endmodule

// File: rtl/pingpong_rx_chk.sv
module pingpong_rx_chk #(
  parameter int DROP_W = 16,
  parameter int IDX_W  = 9,
  parameter int WORDS  = 380
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic [DROP_W-1:0] drop_count,
  input logic [1:0]        done,
  input logic [1:0]        ie,
  input logic              gie,
  input logic [1:0]        set_done,
  input logic              frame_done,
  input logic              drop_evt,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_word
);
  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(gie && |(set_done & ~done & ie)));

  // R3
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(done & ~$past(done) & ~$past(set_done))));

  // R3
  done_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> ((done & $past(set_done)) == $past(set_done)));

  // R6
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> (done == 2'b11));

  // R6
  drop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (drop_count == $past(drop_count) + DROP_W'(1)));

  // R10
  no_spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_word < IDX_W'(WORDS)));

endmodule

bind pingpong_rx pingpong_rx_chk #(.DROP_W(DROP_W), .IDX_W(IDX_W), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .drop_count(drop_count),
  .done(done_q), .ie(ie_q), .gie(gie_q), .set_done(set_done),
  .frame_done(frame_done), .drop_evt(drop_evt), .wr_en(wr_en),
  .wr_word(wr_word)
);

// File: tb/sim_pingpong_rx.sv
module sim_pingpong_rx;
  localparam logic [12:0] GIE  = 13'h07F8;
  localparam logic [12:0] ST0  = 13'h17FC;
  localparam logic [12:0] ST1  = 13'h1FFC;
  localparam logic [12:0] B0   = 13'h1000;
  localparam logic [12:0] B1   = 13'h1800;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_sof, rx_eof;
  logic [7:0]  rx_data;
  logic [12:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  logic [15:0] drop_count;

  int total = 0;
  int bad = 0;
  int irq_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pingpong_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .drop_count(drop_count)
  );

  always @(negedge clk) if (rst_n === 1'b1 && irq === 1'b1) irq_cnt++;

  function automatic logic [7:0] pat(logic [7:0] seed, int i);
    return seed + 8'(i);
  endfunction

  function automatic logic [31:0] pat_word(logic [7:0] seed, int w);
    return {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(logic [12:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic send_frame(int len, logic [7:0] seed, int hit,
                            logic [12:0] haddr, logic [31:0] hdata);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = (i == len - 1);
      rx_data  = pat(seed, i);
      if (i == hit) begin
        bus_addr = haddr; bus_wdata = hdata; bus_we = 1'b1;
      end else begin
        bus_we = 1'b0;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; bus_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 drop_count", {16'd0, drop_count}, 32'd0);
    bus_read(ST0, d); chk("R1 status0", d, 32'd0);
    bus_read(ST1, d); chk("R1 status1", d, 32'd0);
    bus_read(GIE, d); chk("R1 gie", d, 32'd0);
  endtask

  task automatic t_config();
    logic [31:0] d;
    bus_write(GIE, 32'h8000_0000);
    bus_read(GIE, d); chk("R8 gie readback", d, 32'h8000_0000);
    bus_write(ST0, 32'h0000_0009);
    bus_read(ST0, d); chk("R7 write one keeps done clear", d, 32'h8);
    bus_write(ST1, 32'h0);
  endtask

  task automatic t_first_frame();
    logic [31:0] d;
    int i0 = irq_cnt;
    send_frame(20, 8'h10, -1, 13'h0, 32'h0);
    chk("R9 irq one pulse", 32'(irq_cnt - i0), 32'd1);
    bus_read(ST0, d); chk("R3 R1 status0 done", d, 32'h9);
    bus_read(ST1, d); chk("R1 status1 untouched", d, 32'h0);
    bus_read(B0, d); chk("R2 buf0 word0", d, pat_word(8'h10, 0));
    bus_read(B0 + 13'd12, d); chk("R2 buf0 word3 type field", d, pat_word(8'h10, 3));
    bus_read(B0 + 13'd16, d); chk("R2 buf0 word4", d, pat_word(8'h10, 4));
  endtask

  task automatic t_second_frame();
    logic [31:0] d;
    int i0 = irq_cnt;
    send_frame(7, 8'h30, -1, 13'h0, 32'h0);
    chk("R9 no irq with ie clear", 32'(irq_cnt - i0), 32'd0);
    bus_read(ST1, d); chk("R4 status1 done", d, 32'h1);
    bus_read(B1 + 13'd4, d); chk("R4 buf1 word1 lanes", d & 32'h00FF_FFFF,
                                 pat_word(8'h30, 1) & 32'h00FF_FFFF);
  endtask

  task automatic t_both_full();
    logic [31:0] d;
    send_frame(5, 8'h55, -1, 13'h0, 32'h0);
    chk("R6 drop counted", {16'd0, drop_count}, 32'd1);
    bus_read(ST0, d); chk("R6 status0 kept", d, 32'h9);
    bus_read(ST1, d); chk("R6 status1 kept", d, 32'h1);
    bus_read(B0, d); chk("R6 buf0 kept", d, pat_word(8'h10, 0));
    bus_read(B1, d); chk("R6 buf1 kept", d, pat_word(8'h30, 0));
  endtask

  task automatic t_skip();
    logic [31:0] d;
    int i0;
    bus_write(ST1, 32'h8);
    bus_read(ST1, d); chk("R7 release buf1", d, 32'h8);
    i0 = irq_cnt;
    send_frame(16, 8'h40, -1, 13'h0, 32'h0);
    chk("R9 irq buf1 enabled", 32'(irq_cnt - i0), 32'd1);
    bus_read(ST1, d); chk("R5 skip into buf1", d, 32'h9);
    bus_read(ST0, d); chk("R5 buf0 still held", d, 32'h9);
    bus_read(B1 + 13'd12, d); chk("R5 buf1 word3", d, pat_word(8'h40, 3));
  endtask

  task automatic t_gie_off();
    logic [31:0] d;
    int i0;
    bus_write(GIE, 32'h0);
    bus_write(ST0, 32'h8);
    bus_read(ST0, d); chk("R7 release buf0", d, 32'h8);
    i0 = irq_cnt;
    send_frame(30, 8'h70, -1, 13'h0, 32'h0);
    chk("R9 no irq with gie clear", 32'(irq_cnt - i0), 32'd0);
    bus_read(ST0, d); chk("R4 buf0 done again", d, 32'h9);
    bus_read(B0 + 13'd24, d); chk("R2 buf0 word6", d, pat_word(8'h70, 6));
  endtask

  task automatic t_start_vs_release();
    logic [31:0] d;
    send_frame(4, 8'h90, 0, ST1, 32'h8);
    chk("R12 drop at start", {16'd0, drop_count}, 32'd2);
    bus_read(ST1, d); chk("R12 release still applied", d, 32'h8);
    bus_read(B1, d); chk("R12 buf1 not written", d, pat_word(8'h40, 0));
  endtask

  task automatic t_end_vs_release();
    logic [31:0] d;
    send_frame(9, 8'hA0, 8, ST0, 32'h8);
    bus_read(ST0, d); chk("R7 release at end cycle", d, 32'h8);
    bus_read(ST1, d); chk("R3 done at end cycle", d, 32'h9);
    bus_read(B1 + 13'd4, d); chk("R2 buf1 word1", d, pat_word(8'hA0, 1));
  endtask

  task automatic t_truncate();
    logic [31:0] d;
    send_frame(1530, 8'h05, -1, 13'h0, 32'h0);
    bus_read(ST0, d); chk("R10 done after long frame", d, 32'h9);
    bus_read(B0 + 13'd1512, d); chk("R10 word 378", d, pat_word(8'h05, 378));
    bus_read(B0 + 13'd1516, d); chk("R10 word 379 low lanes", d & 32'hFFFF,
                                    pat_word(8'h05, 379) & 32'hFFFF);
    bus_read(B1, d); chk("R10 no spill to buf1", d, pat_word(8'hA0, 0));
    chk("R10 no drop", {16'd0, drop_count}, 32'd2);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_read(13'h0100, d); chk("R11 unmapped zero", d, 32'h0);
    bus_read(B0 + 13'd1520, d); chk("R11 past capacity zero", d, 32'h0);
    bus_read(B1, d); chk("R11 one cycle latency", d, pat_word(8'hA0, 0));
  endtask

  initial begin
    rst_n = 1'b0;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'h0;
    bus_addr = 13'h0; bus_we = 1'b0; bus_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_config();
    t_first_frame();
    t_second_frame();
    t_both_full();
    t_skip();
    t_gie_off();
    t_start_vs_release();
    t_end_vs_release();
    t_truncate();
    t_unmapped();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule